// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Controller

This block serves byte and 16-bit word requests at any byte address from a pair of byte-wide storage banks. Address bit 0 picks the bank: even addresses live in the low bank, which drives data lines 7:0, and odd addresses live in the high bank, which drives lines 15:8. Address bits above bit 0 form the row index that both banks share. A word at an even address uses both banks in one access. A word at an odd address is split into two accesses in sequence. The first access touches the high bank at the odd address, and the second touches the low bank at the next row. The bytes are swapped between lanes so that the lower address always holds the least significant byte.

Requests enter on a valid/ready handshake. `req_ready` is high only when the block is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. While the block is busy the requester must keep its request stable or withdraw it. Nothing is taken until `req_ready` returns. Each completed request produces a one-cycle `rsp_valid` pulse. This response cannot be stalled, so the consumer must take it in that cycle. The pins for the bank lane enables, the row and the write lanes are brought out so that the access pattern can be observed.

Top module: `bytelane_mem_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `busy`=0, `rsp_valid`=0, and both bank enables are inactive (`bank_a0`=1, `bank_bhe_n`=1).
- R2: A byte request at an even address makes one access cycle with `bank_a0`=0 and `bank_bhe_n`=1, at row `addr[AW-1:1]`.
- R3: A byte request at an odd address makes one access cycle with `bank_a0`=1 and `bank_bhe_n`=0, at row `addr[AW-1:1]`.
- R4: A word request at an even address makes one access cycle with `bank_a0`=0 and `bank_bhe_n`=0, and carries write bits 7:0 on lane 7:0 and bits 15:8 on lane 15:8.
- R5: A word request at an odd address makes two access cycles. The first has `bank_a0`=1, `bank_bhe_n`=0 and row `addr[AW-1:1]`. The second has `bank_a0`=0, `bank_bhe_n`=1 and that row plus one, wrapping modulo 2^(AW-1). The lanes carry write bits 7:0 on lane 15:8 and bits 15:8 on lane 7:0.
- R6: For a byte write, write bits 7:0 appear on both halves of `bank_wlane`, and only the enabled bank is changed. The byte at the neighbouring address keeps its value.
- R7: Read data is right-aligned for a byte, with bits 15:8 set to zero. For a word, bits 7:0 come from the lower address and bits 15:8 from the address after it, at both alignments.
- R8: `busy` is high from the cycle after a request is accepted through its last access cycle. During that time `req_ready` is low, and a presented request is not taken and has no effect on memory.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle right after the last access cycle, for both reads and writes. In that cycle `busy`=0.
- R10: `bank_we` is high in every access cycle of a write and low in every access cycle of a read.
- R11: The storage behaves as one byte-addressed memory of 2^AW bytes. Every read returns the bytes last written at those addresses under any mix of sizes and alignments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data, byte in bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_valid on reads |
| busy | output | 1 | Access in progress, high across both halves of a split |
| bank_a0 | output | 1 | Low-bank select, active low |
| bank_bhe_n | output | 1 | High-bank enable, active low |
| bank_row | output | AW-1 | Shared row index |
| bank_we | output | 1 | Write strobe for enabled banks |
| bank_wlane | output | 16 | Write data as placed on the two lanes |

## Verification
If the sequencer holds the wrong phase, the fault shows on the lane enables in the access cycle itself. A split access that skips its second half shows `rsp_valid` one cycle early. A second half that runs without cause makes `busy` last one cycle too long. A wrong row increment or lane swap shows on `bank_row` and `bank_wlane` in the failing cycle. It also shows as a corrupted word on the next read of those addresses. A request taken while busy corrupts a byte that a later read exposes.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    K_BYTE_EVEN = 2'd0,
    K_BYTE_ODD  = 2'd1,
    K_WORD_EVEN = 2'd2,
    K_WORD_ODD  = 2'd3
  } kind_e;

  function automatic kind_e classify(input logic is_word, input logic odd);
    if (is_word) return odd ? K_WORD_ODD : K_WORD_EVEN;
    return odd ? K_BYTE_ODD : K_BYTE_EVEN;
  endfunction
endpackage

// File: rtl/bl_seq.sv
module bl_seq
  import bl_pkg::*;
#(
  parameter int AW = 10,
  localparam int ROW_W = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_word,
  input  logic [AW-1:0]    req_addr,
  input  logic [15:0]      req_wdata,
  output logic             req_ready,
  output phase_e           phase,
  output kind_e            kind,
  output logic [ROW_W-1:0] base_row,
  output logic             write_q,
  output logic [15:0]      wdata_q,
  output logic             rsp_valid,
  output kind_e            rsp_kind
);
  phase_e phase_q;

  assign phase     = phase_q;
  assign req_ready = (phase_q == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind      <= K_BYTE_EVEN;
      base_row  <= '0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= K_BYTE_EVEN;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            kind     <= classify(req_word, req_addr[0]);
            base_row <= req_addr[AW-1:1];
            write_q  <= req_write;
            wdata_q  <= req_wdata;
            phase_q  <= PH_FIRST;
          end
        end
        PH_FIRST: begin
          if (kind == K_WORD_ODD) begin
            phase_q <= PH_SECOND;
          end else begin
            phase_q   <= PH_IDLE;
            rsp_valid <= 1'b1;
            rsp_kind  <= kind;
          end
        end
        PH_SECOND: begin
          phase_q   <= PH_IDLE;
          rsp_valid <= 1'b1;
          rsp_kind  <= kind;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bl_lane_plan.sv
module bl_lane_plan
  import bl_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  phase_e           phase,
  input  kind_e            kind,
  input  logic [ROW_W-1:0] base_row,
  input  logic [15:0]      wdata,
  output logic [1:0]       bank_en,
  output logic [ROW_W-1:0] row,
  output logic [1:0][7:0]  lane
);
  always_comb begin
    bank_en = 2'b00;
    if (phase != PH_IDLE) begin
      unique case (kind)
        K_BYTE_EVEN: bank_en = 2'b01;
        K_BYTE_ODD:  bank_en = 2'b10;
        K_WORD_EVEN: bank_en = 2'b11;
        K_WORD_ODD:  bank_en = (phase == PH_SECOND) ? 2'b01 : 2'b10;
        default:     bank_en = 2'b00;
      endcase
    end
  end

  assign row = (phase == PH_SECOND) ? base_row + ROW_W'(1) : base_row;

  always_comb begin
    unique case (kind)
      K_WORD_EVEN: begin lane[0] = wdata[7:0];  lane[1] = wdata[15:8]; end
      K_WORD_ODD:  begin lane[0] = wdata[15:8]; lane[1] = wdata[7:0];  end
      default:     begin lane[0] = wdata[7:0];  lane[1] = wdata[7:0];  end
    endcase
  end
endmodule

// File: rtl/bl_bank.sv
module bl_bank #(
  parameter int ROW_W = 9,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[row] <= wbyte;
      else    rbyte      <= cells[row];
    end
  end
endmodule

// File: rtl/bytelane_mem_ctrl.sv
module bytelane_mem_ctrl
  import bl_pkg::*;
#(
  parameter int AW = 10,
  localparam int ROW_W = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_word,
  input  logic [AW-1:0]    req_addr,
  input  logic [15:0]      req_wdata,
  output logic             rsp_valid,
  output logic [15:0]      rsp_rdata,
  output logic             busy,
  output logic             bank_a0,
  output logic             bank_bhe_n,
  output logic [ROW_W-1:0] bank_row,
  output logic             bank_we,
  output logic [15:0]      bank_wlane
);
  phase_e           phase;
  kind_e            kind, rsp_kind;
  logic [ROW_W-1:0] base_row;
  logic             write_q;
  logic [15:0]      wdata_q;
  logic [1:0]       bank_en;
  logic [1:0][7:0]  lane, rd;

  bl_seq #(.AW(AW)) u_seq (
    .clk, .rst_n, .req_valid, .req_write, .req_word, .req_addr, .req_wdata,
    .req_ready, .phase, .kind, .base_row, .write_q, .wdata_q,
    .rsp_valid, .rsp_kind
  );

  bl_lane_plan #(.ROW_W(ROW_W)) u_plan (
    .phase, .kind, .base_row, .wdata(wdata_q),
    .bank_en, .row(bank_row), .lane
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_bank
    bl_bank #(.ROW_W(ROW_W)) u_bank (
      .clk, .en(bank_en[gi]), .we(write_q), .row(bank_row),
      .wbyte(lane[gi]), .rbyte(rd[gi])
    );
  end

  assign busy       = (phase != PH_IDLE);
  assign bank_a0    = ~bank_en[0];
  assign bank_bhe_n = ~bank_en[1];
  assign bank_we    = busy & write_q;
  assign bank_wlane = {lane[1], lane[0]};

  always_comb begin
    unique case (rsp_kind)
      K_BYTE_EVEN: rsp_rdata = {8'h00, rd[0]};
      K_BYTE_ODD:  rsp_rdata = {8'h00, rd[1]};
      K_WORD_EVEN: rsp_rdata = {rd[1], rd[0]};
      K_WORD_ODD:  rsp_rdata = {rd[0], rd[1]};
      default:     rsp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_chk.sv
module bl_chk #(
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             rsp_valid,
  input logic             bank_a0,
  input logic             bank_bhe_n,
  input logic [ROW_W-1:0] bank_row
);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R2
  busy_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(bank_a0 && bank_bhe_n));

  // R5
  split_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !bank_a0 && bank_bhe_n) |->
      (bank_row == ROW_W'($past(bank_row) + 1'b1)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind bytelane_mem_ctrl bl_chk #(.ROW_W(ROW_W)) u_bl_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .bank_a0(bank_a0),
  .bank_bhe_n(bank_bhe_n), .bank_row(bank_row)
);

// File: tb/bytelane_mem_ctrl_bench.sv
module bytelane_mem_ctrl_bench;
  localparam int AW = 10;
  localparam int ROW_W = AW - 1;
  localparam int NB = 1 << AW;
  localparam logic [AW-1:0] STRAY = 10'h155;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, bank_a0, bank_bhe_n, bank_we;
  logic [15:0] rsp_rdata, bank_wlane;
  logic [ROW_W-1:0] bank_row;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [NB];

  always #10 clk = ~clk;

  bytelane_mem_ctrl #(.AW(AW)) u_bytelane_mem_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_word, .req_addr,
    .req_wdata, .rsp_valid, .rsp_rdata, .busy, .bank_a0, .bank_bhe_n,
    .bank_row, .bank_we, .bank_wlane
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_lanes(input bit word, input bit odd,
                                            input logic [15:0] w);
    if (!word) return {w[7:0], w[7:0]};
    return odd ? {w[7:0], w[15:8]} : w;
  endfunction

  function automatic logic [15:0] exp_read(input bit word, input logic [AW-1:0] a);
    if (!word) return {8'h00, ref_mem[a]};
    return {ref_mem[AW'(a + 1'b1)], ref_mem[a]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_req(input bit wr, input bit word, input logic [AW-1:0] a,
                        input logic [15:0] w, input bit stray);
    bit odd = a[0];
    bit split = word && odd;
    logic [ROW_W-1:0] r0 = a[AW-1:1];
    logic [15:0] exp_rd = exp_read(word, a);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 idle before request",
          {req_ready, rsp_valid}, 2'b10);
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R8 busy in first access", {busy, req_ready}, 2'b10);
    if (stray) begin
      req_valid = 1'b1; req_write = 1'b1; req_word = 1'b0;
      req_addr = STRAY; req_wdata = 16'h00EE;
    end
    if (word && !odd)
      check(bank_a0 == 1'b0 && bank_bhe_n == 1'b0, "R4 aligned word enables",
            {bank_a0, bank_bhe_n}, 2'b00);
    else if (odd)
      check(bank_a0 == 1'b1 && bank_bhe_n == 1'b0, "R3/R5 odd first enables",
            {bank_a0, bank_bhe_n}, 2'b10);
    else
      check(bank_a0 == 1'b0 && bank_bhe_n == 1'b1, "R2 even byte enables",
            {bank_a0, bank_bhe_n}, 2'b01);
    check(bank_row == r0, "R2 R3 R5 first row", bank_row, r0);
    check(bank_we == wr, "R10 write strobe", bank_we, wr);
    if (wr) check(bank_wlane == exp_lanes(word, odd, w), "R4 R5 R6 write lanes",
                  bank_wlane, exp_lanes(word, odd, w));
    if (split) begin
      @(negedge clk);
      check(busy && !req_ready, "R8 busy across split", {busy, req_ready}, 2'b10);
      check(bank_a0 == 1'b0 && bank_bhe_n == 1'b1 && bank_row == ROW_W'(r0 + 1'b1),
            "R5 second half", {bank_a0, bank_bhe_n, bank_row},
            {2'b01, ROW_W'(r0 + 1'b1)});
      check(bank_we == wr, "R10 write strobe second", bank_we, wr);
      if (wr) check(bank_wlane == exp_lanes(1'b1, 1'b1, w), "R5 lane swap",
                    bank_wlane, exp_lanes(1'b1, 1'b1, w));
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1 && busy == 1'b0, "R9 response pulse",
          {rsp_valid, busy}, 2'b10);
    if (!wr) check(rsp_rdata == exp_rd, "R7 R11 read data", rsp_rdata, exp_rd);
    if (wr) begin
      if (word) begin
        ref_mem[a] = w[7:0];
        ref_mem[AW'(a + 1'b1)] = w[15:8];
      end else begin
        ref_mem[a] = w[7:0];
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    // R1: reset state
    check(req_ready && !busy && !rsp_valid && bank_a0 && bank_bhe_n, "R1 reset",
          {req_ready, busy, rsp_valid, bank_a0, bank_bhe_n}, 5'b10011);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(req_ready && !busy && !rsp_valid && bank_a0 && bank_bhe_n, "R1 after release",
          {req_ready, busy, rsp_valid, bank_a0, bank_bhe_n}, 5'b10011);

    for (int i = 0; i < NB; i += 2)
      do_req(1'b1, 1'b1, AW'(i), 16'(($urandom() & 16'hFFFF) ^ i), 1'b0);

    // R6: byte writes touch only their bank
    do_req(1'b1, 1'b0, 10'h040, 16'hA55A, 1'b0);
    do_req(1'b0, 1'b0, 10'h041, 16'h0000, 1'b0);
    do_req(1'b1, 1'b0, 10'h043, 16'h3CC3, 1'b0);
    do_req(1'b0, 1'b1, 10'h042, 16'h0000, 1'b0);
    // R5: split word crossing a row, and wrap at the top
    do_req(1'b1, 1'b1, 10'h0FF, 16'hBEEF, 1'b0);
    do_req(1'b0, 1'b1, 10'h0FF, 16'h0000, 1'b0);
    do_req(1'b0, 1'b1, 10'h0FE, 16'h0000, 1'b0);
    do_req(1'b0, 1'b1, 10'h100, 16'h0000, 1'b0);
    do_req(1'b1, 1'b1, 10'h3FF, 16'h1234, 1'b0);
    do_req(1'b0, 1'b0, 10'h000, 16'h0000, 1'b0);
    do_req(1'b0, 1'b1, 10'h3FF, 16'h0000, 1'b0);
    // R8: requests presented while busy are ignored
    do_req(1'b0, 1'b1, 10'h021, 16'h0000, 1'b1);
    do_req(1'b1, 1'b1, 10'h022, 16'h7788, 1'b1);
    do_req(1'b0, 1'b0, STRAY, 16'h0000, 1'b0);

    for (int i = 0; i < 400; i++)
      do_req(1'($urandom()), 1'($urandom()), AW'($urandom()),
             16'($urandom()), 1'($urandom() % 8 == 0));
    do_req(1'b0, 1'b0, STRAY, 16'h0000, 1'b0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 pulse ends", rsp_valid, 1'b0);
    finish_run();
  end
endmodule